// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a wide synchronous up-counter built from identical 4-bit stages. Each stage holds one nibble of the count. It can be cleared or preset on a clock edge, and it advances only when two separate enables are both high. The first enable, the advance enable, is shared by every stage. The second enable, the chain enable, arrives at the lowest stage from outside. Every higher stage receives it as the carry of the stage below.

A stage raises its carry only while its nibble is all ones and its own chain enable is high. That carry follows the chain enable in the same cycle, with no register in between. As a result, the whole chain steps as one binary counter. The carry of the top stage leaves the block as the terminal carry, so a higher-level counter can extend the count further.

Clear, preset and both enables are plain level controls that are sampled at the rising edge. The block has no streaming interface, so no back-pressure rules apply to it.

Top module: `ctr_cascade`

## Requirements
- R1: When sclr_n is low at a rising edge, the whole count becomes zero on that edge. This happens whatever preset_n, cnt_en and chain_en are doing.
- R2: When sclr_n is high and preset_n is low at a rising edge, the count takes pre_val on that edge. cnt_en and chain_en have no effect on that edge.
- R3: When sclr_n and preset_n are both high, and cnt_en and chain_en are both high at a rising edge, the count increases by exactly one.
- R4: When sclr_n and preset_n are both high and either cnt_en or chain_en is low, the count keeps its value. This applies to every stage.
- R5: The count runs in natural binary order. An advance from all ones gives zero, and every nibble wraps together.
- R6: carry_out is high exactly when every bit of count is one and chain_en is high. It follows chain_en within the same cycle, with no clock edge in between.
- R7: On an advancing edge, nibble k (bits 4k+3 down to 4k) changes only when all bits below it are ones.
- R8: After a clear, count reads zero and carry_out reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all stages |
| sclr_n | input | 1 | Synchronous clear, active low, highest priority |
| preset_n | input | 1 | Synchronous preset from pre_val, active low |
| cnt_en | input | 1 | Advance enable shared by all stages |
| chain_en | input | 1 | Chain enable into the lowest stage; it also gates carry_out |
| pre_val | input | 4*STAGES | Value taken by the preset |
| count | output | 4*STAGES | Current count |
| carry_out | output | 1 | Terminal carry: count is all ones and chain_en is high |

## Verification
The hardest event to reach from the ports is the full-width wrap. From zero, it takes 2^16 advancing edges before every nibble ripples at once, and random stimulus alone almost never gets there. The stimulus therefore presets values just below all ones, or with only some lower nibbles full, and then advances. This exercises the ripple into each stage and the final wrap to zero. The combinational carry is checked by changing chain_en between edges while the count is all ones, and sampling carry_out before the next edge.

// File: rtl/ctr_chain_pkg.sv
package ctr_chain_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STEP  = 2'd2,
    OP_HOLD  = 2'd3
  } stage_op_e;
endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import ctr_chain_pkg::*;
(
  input  logic      sclr_n,
  input  logic      preset_n,
  input  logic      cnt_en,
  input  logic      chain_en,
  output stage_op_e op
);
  // Fixed priority: clear, then preset, then advance, else hold.
  always_comb begin
    if (!sclr_n)                 op = OP_CLEAR;
    else if (!preset_n)          op = OP_LOAD;
    else if (cnt_en && chain_en) op = OP_STEP;
    else                         op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_nibble.sv
module ctr_nibble
  import ctr_chain_pkg::*;
#(
  parameter int W = NIB_W
) (
  input  logic         clk,
  input  logic         sclr_n,
  input  logic         preset_n,
  input  logic         cnt_en,
  input  logic         chain_en,
  input  logic [W-1:0] pre_val,
  output logic [W-1:0] count,
  output logic         carry_out
);
  stage_op_e    op;
  logic [W-1:0] q;
  logic         armed;

  ctr_op_decode u_dec (
    .sclr_n  (sclr_n),
    .preset_n(preset_n),
    .cnt_en  (cnt_en),
    .chain_en(chain_en),
    .op      (op)
  );

  always_ff @(posedge clk) begin
    unique case (op)
      OP_CLEAR: q <= '0;
      OP_LOAD:  q <= pre_val;
      OP_STEP:  q <= q + W'(1);
      default:  q <= q;
    endcase
  end

  // Set by the first clear; gates the checks until state is known.
  always_ff @(posedge clk) begin
    if (!sclr_n) armed <= 1'b1;
  end

  assign count     = q;
  assign carry_out = (&q) & chain_en;

  a_r1_clear: assert property (@(posedge clk) disable iff (!armed)
    !sclr_n |=> (count == '0));
  a_r2_load: assert property (@(posedge clk) disable iff (!armed)
    (sclr_n && !preset_n) |=> (count == $past(pre_val)));
  a_r3_step: assert property (@(posedge clk) disable iff (!armed)
    (sclr_n && preset_n && cnt_en && chain_en) |=> (count == W'($past(count) + W'(1))));
  a_r4_hold: assert property (@(posedge clk) disable iff (!armed)
    (sclr_n && preset_n && !(cnt_en && chain_en)) |=> $stable(count));
endmodule

// File: rtl/ctr_cascade.sv
module ctr_cascade
  import ctr_chain_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic                     clk,
  input  logic                     sclr_n,
  input  logic                     preset_n,
  input  logic                     cnt_en,
  input  logic                     chain_en,
  input  logic [NIB_W*STAGES-1:0]  pre_val,
  output logic [NIB_W*STAGES-1:0]  count,
  output logic                     carry_out
);
  localparam int TOTAL_W = NIB_W * STAGES;

  logic [STAGES:0] link;
  logic            armed;

  assign link[0] = chain_en;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    ctr_nibble #(.W(NIB_W)) u_nib (
      .clk      (clk),
      .sclr_n   (sclr_n),
      .preset_n (preset_n),
      .cnt_en   (cnt_en),
      .chain_en (link[k]),
      .pre_val  (pre_val[NIB_W*k +: NIB_W]),
      .count    (count[NIB_W*k +: NIB_W]),
      .carry_out(link[k+1])
    );

    if (k > 0) begin : g_ripple
      a_r7_ripple: assert property (@(posedge clk) disable iff (!armed)
        (sclr_n && preset_n && !(&count[NIB_W*k-1:0]))
        |=> $stable(count[NIB_W*k +: NIB_W]));
    end
  end

  assign carry_out = link[STAGES];

  always_ff @(posedge clk) begin
    if (!sclr_n) armed <= 1'b1;
  end

  a_r5_wrap: assert property (@(posedge clk) disable iff (!armed)
    (sclr_n && preset_n && cnt_en && chain_en && (&count)) |=> (count == '0));

  always_comb begin
    if (armed) begin
      a_r6_carry: assert (carry_out == ((count == {TOTAL_W{1'b1}}) && chain_en));
    end
  end
endmodule

// File: tb/ctr_cascade_bench.sv
module ctr_cascade_bench;
  localparam int ST = 4;
  localparam int W  = 4 * ST;

  logic         clk = 1'b0;
  logic         sclr_n, preset_n, cnt_en, chain_en;
  logic [W-1:0] pre_val, count;
  logic         carry_out;
  logic [W-1:0] exp_q;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  ctr_cascade #(.STAGES(ST)) u_ctr_cascade (
    .clk(clk), .sclr_n(sclr_n), .preset_n(preset_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .pre_val(pre_val), .count(count), .carry_out(carry_out)
  );

  function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic c, logic l,
                                             logic p, logic t, logic [W-1:0] d);
    if (!c)         return '0;
    else if (!l)    return d;
    else if (p && t) return cur + W'(1);
    else            return cur;
  endfunction

  function automatic logic model_carry(logic [W-1:0] cur, logic t);
    return (&cur) && t;
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Called right after a negedge: drive, check the carry, then check the count at the next negedge.
  task automatic apply(logic c, logic l, logic p, logic t, logic [W-1:0] d, string req);
    sclr_n = c; preset_n = l; cnt_en = p; chain_en = t; pre_val = d;
    #1;
    chk(carry_out == model_carry(exp_q, t), "R6 carry", W'(carry_out), W'(model_carry(exp_q, t)));
    exp_q = model_next(exp_q, c, l, p, t, d);
    @(negedge clk);
    chk(count == exp_q, req, count, exp_q);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    exp_q = '0;
    sclr_n = 1'b0; preset_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1; pre_val = '0;
    @(negedge clk);
    // R8 reset state
    apply(1'b0, 1'b0, 1'b1, 1'b1, 16'hABCD, "R8 reset");
    chk(carry_out == 1'b0, "R8 carry after clear", W'(carry_out), '0);

    // R3 plain advance
    for (int i = 0; i < 5; i++) apply(1'b1, 1'b1, 1'b1, 1'b1, '0, "R3 advance");

    // R7 ripple into nibble 1 and nibble 2
    apply(1'b1, 1'b0, 1'b0, 1'b0, 16'h00FE, "R2 load");
    for (int i = 0; i < 3; i++) apply(1'b1, 1'b1, 1'b1, 1'b1, '0, "R7 ripple nib1");
    apply(1'b1, 1'b0, 1'b1, 1'b1, 16'h0FFF, "R2 load ignores enables");
    apply(1'b1, 1'b1, 1'b1, 1'b1, '0, "R7 ripple nib3");

    // R5 full wrap
    apply(1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFD, "R2 load");
    for (int i = 0; i < 4; i++) apply(1'b1, 1'b1, 1'b1, 1'b1, '0, "R5 wrap");

    // R6 carry follows chain_en in the same cycle
    apply(1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, "R2 load");
    apply(1'b1, 1'b1, 1'b0, 1'b1, '0, "R4 hold cnt_en low");
    apply(1'b1, 1'b1, 1'b1, 1'b0, '0, "R4 hold chain_en low");
    chain_en = 1'b1; #1;
    chk(carry_out == 1'b1, "R6 carry rises with chain_en", W'(carry_out), W'(1));
    chain_en = 1'b0; #1;
    chk(carry_out == 1'b0, "R6 carry falls with chain_en", W'(carry_out), '0);
    @(negedge clk);
    chk(count == exp_q, "R4 hold", count, exp_q);

    // R4 freeze mid-count across all stages
    apply(1'b1, 1'b0, 1'b1, 1'b1, 16'h3FFF, "R2 load");
    for (int i = 0; i < 3; i++) apply(1'b1, 1'b1, 1'b0, 1'b1, '0, "R4 freeze all stages");

    // R2 load mid-count
    apply(1'b1, 1'b1, 1'b1, 1'b1, '0, "R3 advance");
    apply(1'b1, 1'b0, 1'b1, 1'b1, 16'h5A5A, "R2 load mid-count");

    // R1 clear beats load
    apply(1'b0, 1'b0, 1'b1, 1'b1, 16'h1234, "R1 clear priority");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic c, l, p, t;
      logic [W-1:0] d;
      c = ($urandom_range(99) >= 3);
      l = ($urandom_range(99) >= 8);
      p = ($urandom_range(99) < 85);
      t = ($urandom_range(99) < 90);
      d = ($urandom_range(3) == 0) ? (16'hFFFF - W'($urandom_range(20))) : W'($urandom);
      apply(c, l, p, t, d, "R3/R4 random mix");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule